// File: doc/BRIEF.md
# Maskable Interrupt Flag Register

This block gathers three single-cycle event pulses from a clock/calendar core: a periodic tick, an alarm match and an update-complete notice. It records each one in a status byte that software reads to learn which events happened. The block keeps the three matching enable bits and the square-wave enable. From flags and enables together it drives an active-low interrupt line in open-drain form: an output-enable signal with a pad value that is always low.

Reading the status byte returns a snapshot that holds steady for as long as the read strobe is high. All flags clear when the strobe drops. Any event that lands while the strobe is high goes into a shadow bit and is posted into the flags on the release cycle, so no event is lost. A flag is set whether or not its enable is on. The interrupt request is simply the OR of flag AND enable, so turning on an enable while its flag is already set raises the line at once. Writing the control byte with its freeze bit set drops the update enable. While the freeze input is high, the update-complete source cannot request an interrupt.

The hardware reset is active low and asynchronous, and it is released through a synchronizer. It clears all enables, flags and shadow bits and releases the line. Control writes made while reset is held have no effect.

Top module: `intr_flag_reg`

## Requirements
- R1: The status byte has IRQF in bit 7, the periodic flag in bit 6, the alarm flag in bit 5 and the update flag in bit 4. Bits 3..0 always read 0.
- R2: A pulse on an event input while no read is in progress sets its flag from the next cycle on, whatever the enable bit holds.
- R3: `irq_oe_o` is 1 exactly while at least one flag has its enable set, and IRQF in the status byte equals `irq_oe_o`. `irq_o` is always 0.
- R4: If a flag is already set when a control write sets its enable, `irq_oe_o` rises in the cycle after the write.
- R5: The first cycle in which `stat_re_i` is high captures the status byte. `stat_rdata_o` keeps that value until the cycle after the strobe falls. At that point every flag and IRQF are cleared.
- R6: An event that arrives while `stat_re_i` is high does not change the visible flags. It is posted to its flag in the cycle after the strobe falls. An event that arrives in the release cycle itself is also kept.
- R7: A control write loads wdata bit 6 into the periodic enable, bit 5 into the alarm enable, bit 4 into the update enable and bit 3 into the square-wave enable. If wdata bit 7 (freeze) is 1, the update enable is forced to 0. `ctl_bits_o` shows {periodic, alarm, update, square-wave} enables, MSB first.
- R8: While `set_mode_i` is 1, the update flag does not drive `irq_oe_o` or IRQF, even when its enable is set. The update flag itself is still set.
- R9: While `rst_ni` is low, and after reset is released, all enables, flags and shadow bits are 0 and `irq_oe_o` is 0. Control writes during reset are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low hardware reset |
| evt_periodic_i | input | 1 | Periodic tick pulse |
| evt_alarm_i | input | 1 | Alarm match pulse |
| evt_update_i | input | 1 | Update-complete pulse |
| ctl_we_i | input | 1 | Control byte write strobe |
| ctl_wdata_i | input | 8 | Control byte write data |
| set_mode_i | input | 1 | Freeze bit state from the control register |
| ctl_bits_o | output | 4 | {periodic, alarm, update, square-wave} enables |
| stat_re_i | input | 1 | Status byte read strobe |
| stat_rdata_o | output | 8 | Status byte |
| irq_oe_o | output | 1 | Interrupt pad drive enable (line pulled low when 1) |
| irq_o | output | 1 | Interrupt pad value, always 0 |

## Verification
On every cycle the assertions check these properties: flags are set by events outside a read, the snapshot holds during a read, the byte is empty after a release with no traffic, shadow bits are posted, the freeze write drops the update enable, the freeze input blocks the update request, and the line matches the IRQF bit. Some behaviour only the bench scenarios can show. These are whole orderings: polling with enables off, late enabling of an already-set flag, multi-cycle reads that catch all three sources, and a reset applied in the middle of activity with a write attempted during it. They also include the exact byte values the software would see at each step.

// File: rtl/ifr_pkg.sv
package ifr_pkg;
  localparam int unsigned NUM_SRC  = 3;
  localparam int unsigned REG_W    = 8;
  localparam int unsigned IRQF_POS = 7;
  localparam int unsigned FLAG_TOP = 6;
  localparam int unsigned FRZ_POS  = 7;
  localparam int unsigned SQWE_POS = 3;
  localparam int unsigned CTL_W    = NUM_SRC + 1;

  typedef enum logic [1:0] {
    SRC_PER = 2'd0,
    SRC_ALM = 2'd1,
    SRC_UPD = 2'd2
  } src_e;

  function automatic int unsigned src_bit(input int unsigned idx);
    return FLAG_TOP - idx;
  endfunction
endpackage

// File: rtl/ifr_rst_sync.sv
module ifr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/ifr_ctl_reg.sv
module ifr_ctl_reg import ifr_pkg::*; (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [REG_W-1:0]   wdata_i,
  output logic [NUM_SRC-1:0] en_o,
  output logic               sqwe_o
);
  logic [NUM_SRC-1:0] en_q, en_d;
  logic               sqwe_q, sqwe_d;
  logic               unused_low;

  assign unused_low = ^wdata_i[SQWE_POS-1:0];

  always_comb begin
    en_d   = en_q;
    sqwe_d = sqwe_q;
    if (we_i) begin
      for (int i = 0; i < NUM_SRC; i++) en_d[i] = wdata_i[src_bit(i)];
      if (wdata_i[FRZ_POS]) en_d[SRC_UPD] = 1'b0;
      sqwe_d = wdata_i[SQWE_POS];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      sqwe_q <= 1'b0;
    end else if (we_i) begin
      en_q   <= en_d;
      sqwe_q <= sqwe_d;
    end
  end

  assign en_o   = en_q;
  assign sqwe_o = sqwe_q;
endmodule

// File: rtl/ifr_rd_port.sv
module ifr_rd_port import ifr_pkg::*; (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             re_i,
  input  logic [REG_W-1:0] live_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             act_o,
  output logic [REG_W-1:0] rdata_o
);
  logic             act_q, act_d;
  logic [REG_W-1:0] snap_q, snap_d;
  logic             start;

  assign start = re_i && !act_q;

  always_comb begin
    act_d  = re_i;
    snap_d = start ? live_i : snap_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= 1'b0;
    else         act_q <= act_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    snap_q <= '0;
    else if (start) snap_q <= snap_d;
  end

  assign busy_o  = re_i;
  assign done_o  = act_q && !re_i;
  assign act_o   = act_q;
  assign rdata_o = act_q ? snap_q : live_i;
endmodule

// File: rtl/ifr_flag_bank.sv
module ifr_flag_bank import ifr_pkg::*; (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               busy_i,
  input  logic               done_i,
  output logic [NUM_SRC-1:0] flag_o,
  output logic [NUM_SRC-1:0] pend_o
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic flag_q, flag_d, pend_q, pend_d;

    always_comb begin
      flag_d = flag_q;
      pend_d = pend_q;
      if (done_i) begin
        flag_d = pend_q | evt_i[g];
        pend_d = 1'b0;
      end else if (busy_i) begin
        pend_d = pend_q | evt_i[g];
      end else begin
        flag_d = flag_q | evt_i[g];
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        flag_q <= 1'b0;
        pend_q <= 1'b0;
      end else begin
        flag_q <= flag_d;
        pend_q <= pend_d;
      end
    end

    assign flag_o[g] = flag_q;
    assign pend_o[g] = pend_q;
  end
endmodule

// File: rtl/intr_flag_reg.sv
module intr_flag_reg import ifr_pkg::*; #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_periodic_i,
  input  logic             evt_alarm_i,
  input  logic             evt_update_i,
  input  logic             ctl_we_i,
  input  logic [REG_W-1:0] ctl_wdata_i,
  input  logic             set_mode_i,
  output logic [CTL_W-1:0] ctl_bits_o,
  input  logic             stat_re_i,
  output logic [REG_W-1:0] stat_rdata_o,
  output logic             irq_oe_o,
  output logic             irq_o
);
  logic               rst_n_s;
  logic [NUM_SRC-1:0] evt, en, en_eff, flags, pend;
  logic               sqwe, rd_busy, rd_done, rd_act, irqf;
  logic [REG_W-1:0]   live;

  ifr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk_i(clk_i), .rst_ni(rst_ni), .rst_no(rst_n_s)
  );

  assign evt[SRC_PER] = evt_periodic_i;
  assign evt[SRC_ALM] = evt_alarm_i;
  assign evt[SRC_UPD] = evt_update_i;

  ifr_ctl_reg u_ctl (
    .clk_i(clk_i), .rst_ni(rst_n_s), .we_i(ctl_we_i), .wdata_i(ctl_wdata_i),
    .en_o(en), .sqwe_o(sqwe)
  );

  ifr_flag_bank u_flags (
    .clk_i(clk_i), .rst_ni(rst_n_s), .evt_i(evt), .busy_i(rd_busy),
    .done_i(rd_done), .flag_o(flags), .pend_o(pend)
  );

  ifr_rd_port u_rd (
    .clk_i(clk_i), .rst_ni(rst_n_s), .re_i(stat_re_i), .live_i(live),
    .busy_o(rd_busy), .done_o(rd_done), .act_o(rd_act), .rdata_o(stat_rdata_o)
  );

  always_comb begin
    en_eff          = en;
    en_eff[SRC_UPD] = en[SRC_UPD] && !set_mode_i;
    irqf            = |(flags & en_eff);
    live            = '0;
    live[IRQF_POS]  = irqf;
    for (int i = 0; i < NUM_SRC; i++) live[src_bit(i)] = flags[i];
  end

  assign ctl_bits_o = {en[SRC_PER], en[SRC_ALM], en[SRC_UPD], sqwe};
  assign irq_oe_o   = irqf;
  assign irq_o      = 1'b0;
endmodule

// File: rtl/intr_flag_reg_chk.sv
module intr_flag_reg_chk (
  input logic       clk_i,
  input logic       rst_n_s,
  input logic       evt_alarm_i,
  input logic       evt_periodic_i,
  input logic       evt_update_i,
  input logic       ctl_we_i,
  input logic [7:0] ctl_wdata_i,
  input logic       set_mode_i,
  input logic [3:0] ctl_bits_o,
  input logic       stat_re_i,
  input logic [7:0] stat_rdata_o,
  input logic       irq_oe_o,
  input logic       rd_act,
  input logic [2:0] pend
);
  a_r2_flag_set: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (evt_alarm_i && !stat_re_i) |=> stat_rdata_o[5]);

  a_r5_snapshot_stable: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (rd_act && stat_re_i) |=> $stable(stat_rdata_o));

  a_r5_clear_on_release: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (rd_act && !stat_re_i && pend == 3'b000 && !evt_alarm_i && !evt_periodic_i
     && !evt_update_i) |=> (stat_rdata_o == 8'h00));

  a_r6_pending_posted: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (rd_act && !stat_re_i && pend[1]) |=> stat_rdata_o[5]);

  a_r7_freeze_drops_upd: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (ctl_we_i && ctl_wdata_i[7]) |=> !ctl_bits_o[1]);

  a_r8_freeze_gate: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (set_mode_i && !ctl_bits_o[3] && !ctl_bits_o[2]) |-> !irq_oe_o);

  a_r3_line_matches_irqf: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    !rd_act |-> (irq_oe_o == stat_rdata_o[7]));

  always @(posedge clk_i) begin
    if (!rst_n_s) begin
      a_r9_reset_quiet: assert (!irq_oe_o && ctl_bits_o == 4'h0);
    end
  end
endmodule

bind intr_flag_reg intr_flag_reg_chk u_chk (
  .clk_i(clk_i), .rst_n_s(rst_n_s), .evt_alarm_i(evt_alarm_i),
  .evt_periodic_i(evt_periodic_i), .evt_update_i(evt_update_i),
  .ctl_we_i(ctl_we_i), .ctl_wdata_i(ctl_wdata_i), .set_mode_i(set_mode_i),
  .ctl_bits_o(ctl_bits_o), .stat_re_i(stat_re_i), .stat_rdata_o(stat_rdata_o),
  .irq_oe_o(irq_oe_o), .rd_act(rd_act), .pend(pend)
);

// File: tb/tb_intr_flag_reg.sv
module tb_intr_flag_reg;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ev_p, ev_a, ev_u, we, setm, re;
  logic [7:0] wd;
  logic [3:0] ctl;
  logic [7:0] st;
  logic       oe, pad;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         finished = 0;

  always #2 clk = ~clk;

  intr_flag_reg dut (
    .clk_i(clk), .rst_ni(rst_n), .evt_periodic_i(ev_p), .evt_alarm_i(ev_a),
    .evt_update_i(ev_u), .ctl_we_i(we), .ctl_wdata_i(wd), .set_mode_i(setm),
    .ctl_bits_o(ctl), .stat_re_i(re), .stat_rdata_o(st), .irq_oe_o(oe), .irq_o(pad)
  );

  typedef struct packed {
    logic [2:0] ev;   // {periodic, alarm, update}
    logic       wr;
    logic [7:0] wd;
    logic       rd;
    logic       oe;
    logic [7:0] st;
    logic [3:0] ctl;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{3'b100, 1'b0, 8'h00, 1'b0, 1'b0, 8'h40, 4'h0}, // R2 periodic, enable off
    '{3'b010, 1'b0, 8'h00, 1'b0, 1'b0, 8'h60, 4'h0}, // R2 alarm
    '{3'b000, 1'b1, 8'h20, 1'b0, 1'b1, 8'hE0, 4'h4}, // R4 late alarm enable
    '{3'b001, 1'b0, 8'h00, 1'b1, 1'b1, 8'hE0, 4'h4}, // R5/R6 read starts, update held
    '{3'b000, 1'b0, 8'h00, 1'b1, 1'b1, 8'hE0, 4'h4}, // R5 snapshot holds
    '{3'b000, 1'b0, 8'h00, 1'b0, 1'b0, 8'h10, 4'h4}, // R6 release posts update
    '{3'b000, 1'b1, 8'h10, 1'b0, 1'b1, 8'h90, 4'h2}, // R7 update enable only
    '{3'b000, 1'b1, 8'h90, 1'b0, 1'b0, 8'h10, 4'h0}, // R7 freeze drops update enable
    '{3'b000, 1'b0, 8'h00, 1'b1, 1'b0, 8'h10, 4'h0}, // R5 read
    '{3'b100, 1'b0, 8'h00, 1'b0, 1'b0, 8'h40, 4'h0}, // R6 event on release cycle kept
    '{3'b000, 1'b1, 8'h48, 1'b0, 1'b1, 8'hC0, 4'h9}  // R3/R7 periodic + square-wave
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle();
    ev_p = 0; ev_a = 0; ev_u = 0; we = 0; wd = 8'h00; re = 0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    idle(); setm = 0; rst_n = 1'b1;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 reset oe", {7'h0, oe}, 8'h00);
    chk("R9 reset ctl", {4'h0, ctl}, 8'h00);
    chk("R9 reset stat", st, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 idle stat", st, 8'h00);

    for (int i = 0; i < NV; i++) begin
      {ev_p, ev_a, ev_u} = VEC[i].ev;
      we = VEC[i].wr; wd = VEC[i].wd; re = VEC[i].rd;
      @(negedge clk);
      chk($sformatf("R3 row %0d oe", i), {7'h0, oe}, {7'h0, VEC[i].oe});
      chk($sformatf("R1/R5 row %0d stat", i), st, VEC[i].st);
      chk($sformatf("R7 row %0d ctl", i), {4'h0, ctl}, {4'h0, VEC[i].ctl});
      chk($sformatf("R3 row %0d pad", i), {7'h0, pad}, 8'h00);
    end
    idle();

    // R8: update flag with enable set while frozen
    we = 1; wd = 8'h00; ev_u = 1; setm = 1;
    @(negedge clk);
    idle(); we = 1; wd = 8'h10;
    @(negedge clk);
    idle();
    chk("R8 frozen oe", {7'h0, oe}, 8'h00);
    chk("R8 frozen stat", st, 8'h50);
    setm = 0;
    @(negedge clk);
    chk("R8 unfrozen oe", {7'h0, oe}, 8'h01);
    chk("R8 unfrozen stat", st, 8'hD0);

    // R9: reset in the middle of activity, write attempted during it
    rst_n = 1'b0;
    @(negedge clk);
    we = 1; wd = 8'h70;
    @(negedge clk);
    chk("R9 mid reset oe", {7'h0, oe}, 8'h00);
    chk("R9 mid reset ctl", {4'h0, ctl}, 8'h00);
    idle(); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 after reset stat", st, 8'h00);
    chk("R9 write ignored ctl", {4'h0, ctl}, 8'h00);

    // R6: multi-cycle read catching all three sources
    re = 1;
    @(negedge clk);
    ev_p = 1;
    @(negedge clk);
    ev_p = 0; ev_a = 1;
    @(negedge clk);
    ev_a = 0; ev_u = 1;
    @(negedge clk);
    ev_u = 0;
    chk("R6 held during read", st, 8'h00);
    re = 0;
    @(negedge clk);
    chk("R6 posted after read", st, 8'h70);
    we = 1; wd = 8'h70;
    @(negedge clk);
    idle();
    chk("R4 enable with flags set oe", {7'h0, oe}, 8'h01);
    chk("R1 full stat", st, 8'hF0);

    finished = 1;
    finish_run();
  end
endmodule